// File: doc/BRIEF.md
# Whole-Device Disable Sequencer

This block decides when a network device is switched off as a whole and when it comes back. A board-level active-low disable input asks for the shutdown. The sequencer ignores that input until the device's non-volatile configuration has been loaded once. After that, a filtered low level on the input puts the device into a disabled mode. In that mode the link is asked to enter its deepest low-power state (L3), the PHY is powered down, and the pad output buffers are tri-stated.

Inside the disabled mode, asserting the host-bus reset has no effect. Releasing it opens a short window in which the device leaves the disabled mode and reloads its configuration. When the reload completes, the device drops back into the disabled mode if the input is still low. Raising the disable input does not simply resume operation. It fires a fixed-length fundamental reset, and then the configuration load starts again. Nothing happens after power-up until the power-good input is high.

The current state is available on a one-hot debug output.

Top module: `devoff_ctrl`

## Requirements
- R1: After the synchronous reset the sequencer is in its power-up state: `state_dbg` = 6'b000001, `cfg_load_req` = 0, `fund_rst` = 0 and `pad_oe` = 1. It stays there with no load request for as long as `pwr_good` is low. The clock after `pwr_good` is seen high, it moves to the load state and raises `cfg_load_req`.
- R2: While the first configuration load is in progress (`state_dbg` = 6'b000010), the disable input has no effect and `dis_mode` stays 0. A `cfg_done` pulse moves the sequencer to the active state (6'b000100).
- R3: The disable input passes through a two-flop synchronizer. Its level is accepted only after the synchronized value has differed from the current level for 4 consecutive clocks. A low run of 3 clocks or fewer never causes the disabled mode, and a run of 4 or more does.
- R4: In the disabled state (6'b001000), `dis_mode` = 1, `phy_pwrdn` = 1, `link_l3_req` = 1 and `pad_oe` = 0. In every other state these outputs are 0, 0, 0 and 1.
- R5: Asserting `host_rst_n` low while disabled, with the disable input still low, leaves the sequencer in the disabled state.
- R6: A synchronized rising edge on `host_rst_n` while disabled moves the sequencer to the reset window (6'b010000). There the disabled outputs are released and `cfg_load_req` = 1. On `cfg_done` it returns to the disabled state if the filtered input is still low.
- R7: When the filtered disable input goes high while disabled, the sequencer enters the fundamental-reset state (6'b100000). `fund_rst` is then high for exactly 16 consecutive clocks, after which the load state is entered with `cfg_load_req` = 1. A high run of 3 clocks or fewer causes no fundamental reset.
- R8: If the disable input has been released when the reset window's `cfg_done` arrives, the sequencer enters the fundamental-reset state instead of the disabled state.
- R9: The state register is always exactly one-hot and is driven onto `state_dbg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dis_req_n | input | 1 | Asynchronous active-low whole-device disable request |
| host_rst_n | input | 1 | Asynchronous active-low host-bus reset |
| pwr_good | input | 1 | Power is stable; link bring-up may begin |
| cfg_done | input | 1 | One-clock pulse: configuration load finished |
| dis_mode | output | 1 | Device is in the disabled mode |
| phy_pwrdn | output | 1 | PHY power-down request |
| pad_oe | output | 1 | Pad output-buffer enable (0 = tri-state) |
| link_l3_req | output | 1 | Request for the link's deepest low-power state |
| fund_rst | output | 1 | Fundamental reset of the whole device |
| cfg_load_req | output | 1 | Request to load the non-volatile configuration |
| state_dbg | output | 6 | One-hot current state |

## Verification
The bench sweeps the disable input through low pulses of 1 to 6 clocks while active, and high pulses of 1 to 6 clocks while disabled. Only runs of 4 or more may change anything. An off-by-one filter would either disable the device on a 3-clock glitch or ignore a genuine 4-clock request. The bench holds the input low through the first configuration load. A sequencer that samples the input too early shows `dis_mode` before `cfg_done`.

The bench toggles the host reset inside the disabled mode. A design that treats reset assertion as an exit, or that fails to reopen the reload window, leaves the disabled state at the wrong moment or never. The bench also measures the fundamental-reset pulse to the clock, and it releases the input in the middle of a reload window. A design that resumes silently there returns to active with no reset pulse.

// File: rtl/devoff_pkg.sv
// Shared types for the whole-device disable sequencer.
// Assumes one-hot state encoding; bit order is visible on the debug port.
package devoff_pkg;

    typedef enum logic [5:0] {
        ST_PWRUP    = 6'b000001,
        ST_LOAD     = 6'b000010,
        ST_ACTIVE   = 6'b000100,
        ST_DISABLED = 6'b001000,
        ST_RSTWIN   = 6'b010000,
        ST_FRESET   = 6'b100000
    } dev_state_t;

endpackage

// File: rtl/devoff_sync2.sv
// Two-flop synchronizer for a single asynchronous level.
// Assumes the input changes slowly relative to clk; reset value selectable.
module devoff_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta;

    // Capture the asynchronous level through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/devoff_pin_filter.sv
// Synchronizes an active-low request and accepts a new level only after
// FILT_LEN consecutive samples that differ from the current one.
// Assumes the released (high) level at reset.
module devoff_pin_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic asserted
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic          pin_s;
    logic          level_n;
    logic [CW-1:0] run_cnt;
    logic          differs;

    devoff_sync2 #(.RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_n),
        .q     (pin_s)
    );

    assign differs  = (pin_s != level_n);
    assign asserted = ~level_n;

    // Count consecutive differing samples and flip the level on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_n <= 1'b1;
            run_cnt <= '0;
        end else if (!differs) begin
            run_cnt <= '0;
        end else if (run_cnt == CW'(FILT_LEN - 1)) begin
            level_n <= pin_s;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    AST_FILTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level_n) |-> ($past(run_cnt) == CW'(FILT_LEN - 1))); // R3
endmodule

// File: rtl/devoff_dwell_cnt.sv
// Counts clocks while run is high; last marks the LEN-th clock of a run.
// Assumes run stays high until last has been seen.
module devoff_dwell_cnt #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt;

    assign last = run && (cnt == CW'(LEN - 1));

    // Advance during a run, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (!last) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_DWELL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run && !last |=> (cnt != '0) || !run); // R7
endmodule

// File: rtl/devoff_ctrl.sv
// Whole-device disable sequencer. Gates start-up on power-good, loads the
// configuration, then follows a filtered active-low disable request.
// Host-reset release while disabled opens a reload window; releasing the
// request issues a fixed-length fundamental reset followed by a new load.
// Assumes cfg_done is a synchronous one-clock pulse.
module devoff_ctrl #(
    parameter int FILT_LEN   = 4,
    parameter int FRESET_LEN = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dis_req_n,
    input  logic       host_rst_n,
    input  logic       pwr_good,
    input  logic       cfg_done,
    output logic       dis_mode,
    output logic       phy_pwrdn,
    output logic       pad_oe,
    output logic       link_l3_req,
    output logic       fund_rst,
    output logic       cfg_load_req,
    output logic [5:0] state_dbg
);
    import devoff_pkg::*;

    dev_state_t state, state_nx;
    logic       pin_on;
    logic       host_s, host_q, host_rel;
    logic       fr_last;

    devoff_pin_filter #(.FILT_LEN(FILT_LEN)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_n    (dis_req_n),
        .asserted (pin_on)
    );

    devoff_sync2 #(.RST_VAL(1'b1)) u_host_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (host_rst_n),
        .q     (host_s)
    );

    devoff_dwell_cnt #(.LEN(FRESET_LEN)) u_freset (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_FRESET),
        .last  (fr_last)
    );

    // Remember the previous synchronized host reset to find its release.
    always_ff @(posedge clk) begin
        if (!rst_n) host_q <= 1'b1;
        else        host_q <= host_s;
    end

    assign host_rel = host_s && !host_q;

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_PWRUP:    if (pwr_good) state_nx = ST_LOAD;
            ST_LOAD:     if (cfg_done) state_nx = ST_ACTIVE;
            ST_ACTIVE:   if (pin_on)   state_nx = ST_DISABLED;
            ST_DISABLED: if (!pin_on)       state_nx = ST_FRESET;
                         else if (host_rel) state_nx = ST_RSTWIN;
            ST_RSTWIN:   if (cfg_done) state_nx = pin_on ? ST_DISABLED : ST_FRESET;
            ST_FRESET:   if (fr_last)  state_nx = ST_LOAD;
            default:     state_nx = ST_PWRUP;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_PWRUP;
        else        state <= state_nx;
    end

    assign dis_mode     = (state == ST_DISABLED);
    assign phy_pwrdn    = dis_mode;
    assign link_l3_req  = dis_mode;
    assign pad_oe       = !dis_mode;
    assign fund_rst     = (state == ST_FRESET);
    assign cfg_load_req = (state == ST_LOAD) || (state == ST_RSTWIN);
    assign state_dbg    = state;

    AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_dbg) == 1); // R9
    AST_PWRGOOD_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PWRUP) && !pwr_good |=> (state == ST_PWRUP)); // R1
    AST_LOAD_NO_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |=> !dis_mode); // R2
    AST_DISABLE_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dis_mode) |-> $past(pin_on)); // R3
    AST_HOSTRST_NO_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DISABLED) && pin_on && !host_rel |=> (state == ST_DISABLED)); // R5
    AST_WINDOW_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_RSTWIN) |-> $past(host_rel)); // R6
    AST_FRESET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fund_rst) |-> !$past(pin_on)); // R7
    AST_FRESET_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fund_rst) |-> cfg_load_req); // R7
endmodule

// File: tb/devoff_ctrl_tb.sv
`timescale 1ns/1ps
module devoff_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n, dis_req_n, host_rst_n, pwr_good, cfg_done;
    logic       dis_mode, phy_pwrdn, pad_oe, link_l3_req, fund_rst, cfg_load_req;
    logic [5:0] state_dbg;
    int         n_chk = 0;
    int         n_fail = 0;
    int         cfg_dly = 20;
    int         ld_cnt = 0;

    localparam logic [5:0] S_PWRUP = 6'b000001, S_LOAD = 6'b000010,
                           S_ACT = 6'b000100, S_DIS = 6'b001000,
                           S_WIN = 6'b010000, S_FR = 6'b100000;

    always #2 clk = ~clk;

    devoff_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .dis_req_n(dis_req_n), .host_rst_n(host_rst_n),
        .pwr_good(pwr_good), .cfg_done(cfg_done), .dis_mode(dis_mode),
        .phy_pwrdn(phy_pwrdn), .pad_oe(pad_oe), .link_l3_req(link_l3_req),
        .fund_rst(fund_rst), .cfg_load_req(cfg_load_req), .state_dbg(state_dbg)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic wait_state(input logic [5:0] st, input int max_cyc, input string req);
        int n = 0;
        while (state_dbg != st && n < max_cyc) begin
            @(negedge clk);
            n++;
        end
        chk(state_dbg == st, req, int'(state_dbg), int'(st));
    endtask

    task automatic chk_dis_outs(input bit on, input string req);
        chk({dis_mode, phy_pwrdn, link_l3_req, pad_oe} == (on ? 4'b1110 : 4'b0001), req,
            int'({dis_mode, phy_pwrdn, link_l3_req, pad_oe}), on ? 14 : 1);
    endtask

    // Configuration-load stub: done pulse cfg_dly clocks after the request.
    initial begin
        cfg_done = 1'b0;
        forever begin
            @(negedge clk);
            if (cfg_done) begin
                cfg_done = 1'b0;
                ld_cnt   = 0;
            end else if (cfg_load_req === 1'b1) begin
                ld_cnt++;
                if (ld_cnt >= cfg_dly) cfg_done = 1'b1;
            end else begin
                ld_cnt = 0;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=hung expected=finished");
        summary();
    end

    initial begin
        bit seen;
        int n;
        rst_n = 1'b0; dis_req_n = 1'b1; host_rst_n = 1'b1; pwr_good = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(state_dbg == S_PWRUP, "R9 reset state", int'(state_dbg), int'(S_PWRUP));
        chk(!cfg_load_req && !fund_rst && pad_oe, "R1 reset outputs",
            int'({cfg_load_req, fund_rst, pad_oe}), 1);
        repeat (8) @(negedge clk);
        chk(state_dbg == S_PWRUP && !cfg_load_req, "R1 waits for power good",
            int'(state_dbg), int'(S_PWRUP));

        // R2: request held low through the first load.
        dis_req_n = 1'b0; pwr_good = 1'b1;
        @(negedge clk);
        chk(state_dbg == S_LOAD && cfg_load_req, "R1 load after power good",
            int'(state_dbg), int'(S_LOAD));
        seen = 0;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (dis_mode) seen = 1;
        end
        chk(!seen && state_dbg == S_LOAD, "R2 pin ignored during load", int'(seen), 0);
        wait_state(S_DIS, 40, "R2 disable after load");
        chk_dis_outs(1'b1, "R4 disabled outputs");

        // R5: host reset assertion is ignored.
        host_rst_n = 1'b0;
        seen = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (state_dbg != S_DIS) seen = 1;
        end
        chk(!seen, "R5 host reset ignored", int'(seen), 0);

        // R6: release opens the reload window.
        host_rst_n = 1'b1;
        wait_state(S_WIN, 6, "R6 window entry");
        chk_dis_outs(1'b0, "R4 window outputs");
        chk(cfg_load_req == 1'b1, "R6 reload requested", int'(cfg_load_req), 1);
        wait_state(S_DIS, 40, "R6 back to disabled");

        // R7: release produces a fundamental reset of fixed length.
        dis_req_n = 1'b1;
        wait_state(S_FR, 10, "R7 fund reset entry");
        n = 0;
        while (fund_rst && n < 40) begin
            n++;
            @(negedge clk);
        end
        chk(n == 16, "R7 fund reset length", n, 16);
        chk(state_dbg == S_LOAD && cfg_load_req, "R7 reload after reset",
            int'(state_dbg), int'(S_LOAD));
        wait_state(S_ACT, 40, "R7 active again");
        chk_dis_outs(1'b0, "R4 active outputs");

        // R3: low pulse length sweep while active.
        for (int len = 1; len <= 6; len++) begin
            dis_req_n = 1'b0;
            repeat (len) @(negedge clk);
            dis_req_n = 1'b1;
            seen = 0;
            for (int i = 0; i < 14; i++) begin
                @(negedge clk);
                if (dis_mode) seen = 1;
            end
            chk(seen == (len >= 4), "R3 low pulse filter", int'(seen), int'(len >= 4));
            wait_state(S_ACT, 150, "R3 settle active");
        end

        // R7: high pulse length sweep while disabled.
        dis_req_n = 1'b0;
        wait_state(S_DIS, 20, "R3 steady request");
        for (int len = 1; len <= 6; len++) begin
            dis_req_n = 1'b1;
            repeat (len) @(negedge clk);
            dis_req_n = 1'b0;
            seen = 0;
            for (int i = 0; i < 14; i++) begin
                @(negedge clk);
                if (fund_rst) seen = 1;
            end
            chk(seen == (len >= 4), "R7 release pulse filter", int'(seen), int'(len >= 4));
            wait_state(S_DIS, 150, "R7 settle disabled");
        end

        // R8: release during the reload window.
        host_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        host_rst_n = 1'b1;
        wait_state(S_WIN, 8, "R8 window entry");
        dis_req_n = 1'b1;
        wait_state(S_FR, 40, "R8 fund reset after window");
        wait_state(S_ACT, 80, "R8 active after reset");
        chk(!dis_mode && pad_oe, "R8 final outputs", int'({dis_mode, pad_oe}), 1);
        summary();
    end
endmodule